// File: doc/BRIEF.md
# SRAM Self-Test Sequencer

This block runs built-in tests of an external static memory by driving a synchronous memory controller through its command port. It sweeps the whole address space in one of three passes: a fill pass that writes a known pattern everywhere, a verify pass that reads every word back and compares it, and an interleaved pass that alternates one write with one read of the location written a fixed number of steps earlier. Mismatches are counted. A single-shot command deliberately writes a corrupted word, so that the next verify pass has to report it.

Every memory access takes a slot of three cycles, matching the controller's idle, first-access and second-access states. The request goes out in the first cycle. The two cycles after it are quiet. The controller's unregistered read data is sampled in the last cycle of a read slot. The expected word for address `a` is the bitwise inverse of `a`, zero-extended to the data width. A pass is started with a one-cycle pulse on one of the start inputs. The end of a pass is marked by a one-cycle `done` pulse.

Top module: `sram_selftest_seq`

## Requirements
- R1: While reset is asserted and after it is released, `mem_req`, `done`, `err_count` and `inj_count` are all zero.
- R2: A `go_write` pulse in idle clears the step counter. For each step c from 0 to 2^ADDR_W-1 the block then runs one three-cycle slot. In the first cycle of the slot, `mem_req`=1, `mem_rd`=0, `mem_addr`=c and `mem_wdata`=~c. In the next two cycles, `mem_req`=0.
- R3: A `go_read` pulse in idle clears the step counter and `err_count`. The block then runs one read slot per address, with `mem_rd`=1 in the request cycle. In the third cycle of each slot it compares `rd_data` with ~address and adds one to `err_count` on a mismatch.
- R4: A `go_raw` pulse in idle clears the step counter. For each step c, the block runs a write slot to c followed by a read slot at (c-LAG) modulo 2^ADDR_W. The read is compared only when c >= LAG.
- R5: A `go_inject` pulse in idle runs one write slot to the zero-extended `inj_sel` address, with data equal to ~address XOR 1. At the end of that slot, `inj_count` increases by one. The block then returns to idle without a `done` pulse.
- R6: `done` is high for exactly one cycle: the cycle after the third cycle of the last slot of the step in which the counter was all ones. No request is issued in that cycle.
- R7: Start pulses have no effect while a slot sequence is running. When several start pulses arrive together in idle, the priority is write, then read, then interleaved, then inject.
- R8: `inj_count` is cleared only by reset. Only a read-pass start clears `err_count`. Both counters wrap on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| go_write | input | 1 | Start pulse for the fill pass |
| go_read | input | 1 | Start pulse for the verify pass |
| go_raw | input | 1 | Start pulse for the interleaved pass |
| go_inject | input | 1 | Start pulse for one corrupted write |
| inj_sel | input | SEL_W | Address used for the corrupted write |
| rd_data | input | DATA_W | Unregistered read data from the controller |
| mem_req | output | 1 | Command strobe to the controller |
| mem_rd | output | 1 | 1 = read, 0 = write (valid with `mem_req`) |
| mem_addr | output | ADDR_W | Command address |
| mem_wdata | output | DATA_W | Write data |
| err_count | output | ERR_W | Mismatch counter |
| inj_count | output | SEL_W | Corrupted-write counter |
| done | output | 1 | End-of-pass pulse |

## Verification
Some properties are checked on every cycle. Each request is followed by at least one quiet cycle. `done` never lasts two cycles and never coincides with a request. Both counters only step by one, or for the error count return to zero. Every comparison is preceded two cycles earlier by a read request. Whether the addresses, patterns, interleaving lag, suppression window, start priority and counter values are correct can only be shown by the bench scenarios. Those scenarios use a behavioural memory with fault hooks, and a per-cycle model of the expected command stream.

// File: rtl/sts_pkg.sv
package sts_pkg;
  // position inside a three-cycle access slot
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_MID, ST_END} sts_state_e;
  // running test kind
  typedef enum logic [1:0] {MD_WRITE, MD_READ, MD_RAW, MD_INJECT} sts_mode_e;
endpackage

// File: rtl/sts_step_counter.sv
module sts_step_counter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic         at_top
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end
  assign at_top = &cnt;
endmodule

// File: rtl/sts_event_counter.sv
module sts_event_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sts_fsm.sv
module sts_fsm
  import sts_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go_write,
  input  logic       go_read,
  input  logic       go_raw,
  input  logic       go_inject,
  input  logic       at_top,
  output sts_state_e state,
  output sts_mode_e  mode,
  output logic       rd_phase,
  output logic       clr_cnt,
  output logic       clr_err,
  output logic       latch_sel,
  output logic       slot_end,
  output logic       step_end,
  output logic       inject_end
);
  sts_state_e st_d;
  sts_mode_e  md_d;
  logic       rd_d;

  always_comb begin
    st_d       = state;
    md_d       = mode;
    rd_d       = rd_phase;
    clr_cnt    = 1'b0;
    clr_err    = 1'b0;
    latch_sel  = 1'b0;
    step_end   = 1'b0;
    inject_end = 1'b0;
    slot_end   = (state == ST_END);
    case (state)
      ST_IDLE: begin
        // fixed priority among simultaneous starts
        if (go_write) begin
          st_d = ST_REQ; md_d = MD_WRITE; rd_d = 1'b0; clr_cnt = 1'b1;
        end else if (go_read) begin
          st_d = ST_REQ; md_d = MD_READ; rd_d = 1'b1; clr_cnt = 1'b1; clr_err = 1'b1;
        end else if (go_raw) begin
          st_d = ST_REQ; md_d = MD_RAW; rd_d = 1'b0; clr_cnt = 1'b1;
        end else if (go_inject) begin
          st_d = ST_REQ; md_d = MD_INJECT; rd_d = 1'b0; latch_sel = 1'b1;
        end
      end
      ST_REQ: st_d = ST_MID;
      ST_MID: st_d = ST_END;
      default: begin
        if (mode == MD_INJECT) begin
          inject_end = 1'b1;
          st_d       = ST_IDLE;
        end else if (mode == MD_RAW && !rd_phase) begin
          rd_d = 1'b1;            // write half done, lagging read follows
          st_d = ST_REQ;
        end else begin
          step_end = 1'b1;
          rd_d     = (mode == MD_READ);
          st_d     = at_top ? ST_IDLE : ST_REQ;
        end
      end
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode     <= MD_WRITE;
      rd_phase <= 1'b0;
    end else begin
      state    <= st_d;
      mode     <= md_d;
      rd_phase <= rd_d;
    end
  end
endmodule

// File: rtl/sram_selftest_seq.sv
module sram_selftest_seq
  import sts_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int ERR_W  = 16,
  parameter int SEL_W  = 8,
  parameter int LAG    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_write,
  input  logic              go_read,
  input  logic              go_raw,
  input  logic              go_inject,
  input  logic [SEL_W-1:0]  inj_sel,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mem_req,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ERR_W-1:0]  err_count,
  output logic [SEL_W-1:0]  inj_count,
  output logic              done
);
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  localparam addr_t LAG_A = addr_t'(LAG);

  // expected word for an address
  function automatic data_t f_pattern(input addr_t a);
    return ~data_t'(a);
  endfunction

  // deliberately wrong word: lowest bit flipped
  function automatic data_t f_corrupt(input addr_t a);
    return f_pattern(a) ^ data_t'(1);
  endfunction

  // named internal events
  sts_state_e state;
  sts_mode_e  mode;
  logic  rd_phase, clr_cnt, clr_err, latch_sel;
  logic  slot_end, step_end, inject_end, pass_end;
  logic  at_top, lag_ok, cmp_en, mismatch;
  addr_t step_cnt, sel_q, cur_addr;
  logic  done_q;

  sts_fsm u_fsm (
    .clk(clk), .rst(rst),
    .go_write(go_write), .go_read(go_read), .go_raw(go_raw), .go_inject(go_inject),
    .at_top(at_top),
    .state(state), .mode(mode), .rd_phase(rd_phase),
    .clr_cnt(clr_cnt), .clr_err(clr_err), .latch_sel(latch_sel),
    .slot_end(slot_end), .step_end(step_end), .inject_end(inject_end)
  );

  sts_step_counter #(.W(ADDR_W)) u_step (
    .clk(clk), .rst(rst), .clr(clr_cnt), .adv(step_end),
    .cnt(step_cnt), .at_top(at_top)
  );

  sts_event_counter #(.W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .clr(clr_err), .inc(mismatch), .cnt(err_count)
  );

  sts_event_counter #(.W(SEL_W)) u_inj (
    .clk(clk), .rst(rst), .clr(1'b0), .inc(inject_end), .cnt(inj_count)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst)            sel_q <= '0;
    else if (latch_sel) sel_q <= addr_t'(inj_sel);
  end

  // lagging-read suppression window
  generate
    if (LAG == 0) begin : g_nolag
      assign lag_ok = 1'b1;
    end else begin : g_lag
      assign lag_ok = (step_cnt >= LAG_A);
    end
  endgenerate

  always_comb begin
    if (mode == MD_INJECT)                cur_addr = sel_q;
    else if (mode == MD_RAW && rd_phase)  cur_addr = step_cnt - LAG_A;
    else                                  cur_addr = step_cnt;
  end

  assign pass_end = step_end && at_top;
  assign cmp_en   = slot_end && rd_phase && (mode == MD_READ || lag_ok);
  assign mismatch = cmp_en && (rd_data != f_pattern(cur_addr));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= pass_end;
  end

  assign mem_req   = (state == ST_REQ);
  assign mem_rd    = rd_phase;
  assign mem_addr  = cur_addr;
  assign mem_wdata = (mode == MD_INJECT) ? f_corrupt(cur_addr) : f_pattern(cur_addr);
  assign done      = done_q;
endmodule

// File: rtl/sram_selftest_seq_sva.sv
module sram_selftest_seq_sva #(
  parameter int ERR_W = 16,
  parameter int SEL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_req,
  input logic             mem_rd,
  input logic             done,
  input logic             cmp_en,
  input logic [ERR_W-1:0] err_count,
  input logic [SEL_W-1:0] inj_count
);
  // R2: a request is always followed by a quiet cycle
  p_req_gap_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R3: every comparison sits two cycles after a read request
  p_cmp_after_read_r3: assert property (@(posedge clk) disable iff (rst)
    cmp_en |-> ($past(mem_req, 2) && $past(mem_rd, 2)));

  // R3 / R8: error count moves by one or is cleared
  p_err_step_r3: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) |->
      (err_count == ERR_W'($past(err_count) + 1'b1) || err_count == '0));

  // R5 / R8: injection count only ever steps up by one
  p_inj_step_r5: assert property (@(posedge clk) disable iff (rst)
    (inj_count != $past(inj_count)) |-> (inj_count == SEL_W'($past(inj_count) + 1'b1)));

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: no request in the done cycle
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);
endmodule

bind sram_selftest_seq sram_selftest_seq_sva #(.ERR_W(ERR_W), .SEL_W(SEL_W)) u_sva (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_rd(mem_rd), .done(done),
  .cmp_en(cmp_en), .err_count(err_count), .inj_count(inj_count)
);

// File: tb/sram_selftest_seq_bench.sv
module sram_selftest_seq_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go_write = 1'b0, go_read = 1'b0, go_raw = 1'b0, go_inject = 1'b0;
  logic [7:0]    inj_sel = '0;
  logic [DW-1:0] rd_data;
  logic          mem_req, mem_rd, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [15:0]   err_count;
  logic [7:0]    inj_count;

  always #2.5 clk = ~clk;

  sram_selftest_seq #(.ADDR_W(AW), .DATA_W(DW), .ERR_W(16), .SEL_W(8), .LAG(16)) u_sram_selftest_seq (
    .clk(clk), .rst(rst), .go_write(go_write), .go_read(go_read), .go_raw(go_raw),
    .go_inject(go_inject), .inj_sel(inj_sel), .rd_data(rd_data),
    .mem_req(mem_req), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .err_count(err_count), .inj_count(inj_count), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] good_word(input int a);
    return 16'hFFFF - 16'(a);
  endfunction

  // ---------------- behavioural memory behind the controller ----------------
  logic [DW-1:0] mem_arr [N];
  int   fault_addr = -1;
  logic lat_valid = 1'b0, lat_rd = 1'b0;
  logic [AW-1:0] lat_addr = '0;

  initial for (int i = 0; i < N; i++) mem_arr[i] = '0;

  always @(posedge clk) begin
    if (mem_req && !rst) begin
      lat_valid <= 1'b1;
      lat_rd    <= mem_rd;
      lat_addr  <= mem_addr;
      if (!mem_rd)
        mem_arr[mem_addr] <= (int'(mem_addr) == fault_addr) ? (mem_wdata ^ 16'h0100) : mem_wdata;
    end
  end
  assign rd_data = (lat_valid && lat_rd) ? mem_arr[lat_addr] : 16'hBEEF;

  // ---------------- cycle-by-cycle reference model ----------------
  int m_mode = 0;   // 0 idle, 1 fill, 2 verify, 3 interleaved, 4 inject
  int m_slot = 0;
  bit m_rdslot = 0;
  int m_c = 0, m_err = 0, m_inj = 0, m_sel = 0;
  bit m_done = 0;

  function automatic int model_addr();
    if (m_mode == 4) return m_sel;
    if (m_mode == 3 && m_rdslot) return (m_c - 16 + N) % N;
    return m_c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_slot = 0; m_rdslot = 0; m_c = 0; m_err = 0; m_inj = 0; m_sel = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_mode == 0) begin
        m_slot = 0;
        if (go_write)       begin m_mode = 1; m_c = 0; m_rdslot = 0; end
        else if (go_read)   begin m_mode = 2; m_c = 0; m_err = 0; m_rdslot = 1; end
        else if (go_raw)    begin m_mode = 3; m_c = 0; m_rdslot = 0; end
        else if (go_inject) begin m_mode = 4; m_sel = int'(inj_sel) % N; m_rdslot = 0; end
      end else if (m_slot < 2) begin
        m_slot++;
      end else begin
        bit step_over;
        step_over = 0;
        m_slot = 0;
        if (m_rdslot && (m_mode == 2 || m_c >= 16))
          if (mem_arr[model_addr()] != good_word(model_addr())) m_err = (m_err + 1) % 65536;
        case (m_mode)
          4: begin m_inj = (m_inj + 1) % 256; m_mode = 0; end
          3: if (!m_rdslot) m_rdslot = 1; else begin m_rdslot = 0; step_over = 1; end
          default: step_over = 1;
        endcase
        if (step_over) begin
          if (m_c == N - 1) begin m_done = 1; m_mode = 0; end
          m_c = (m_c + 1) % N;
        end
      end
    end
  end

  // per-cycle comparison against the model (R2, R4, R5, R6 streams)
  always @(negedge clk) begin
    if (!rst) begin
      bit exp_req;
      exp_req = (m_mode != 0) && (m_slot == 0);
      check(mem_req == exp_req, "R2 stream mem_req", mem_req, exp_req);
      if (exp_req) begin
        logic [15:0] exp_wd;
        exp_wd = (m_mode == 4) ? (good_word(m_sel) ^ 16'h0001) : good_word(model_addr());
        check(mem_rd == m_rdslot, "R4 stream mem_rd", mem_rd, m_rdslot);
        check(int'(mem_addr) == model_addr(), "R4 stream mem_addr", mem_addr, model_addr());
        if (!m_rdslot) check(mem_wdata == exp_wd, "R5 stream mem_wdata", mem_wdata, exp_wd);
      end
      check(done == m_done, "R6 stream done", done, m_done);
      check(int'(err_count) == m_err, "R3 stream err_count", err_count, m_err);
      check(int'(inj_count) == m_inj, "R5 stream inj_count", inj_count, m_inj);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic start(input bit w, input bit r, input bit x, input bit j, input logic [7:0] s);
    @(negedge clk); #1;
    go_write = w; go_read = r; go_raw = x; go_inject = j; inj_sel = s;
    @(negedge clk); #1;
    go_write = 0; go_read = 0; go_raw = 0; go_inject = 0;
  endtask

  task automatic wait_done(input string tag);
    bit seen;
    seen = 0;
    for (int i = 0; i < 4 * 3 * N && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen, tag, seen, 1);
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bad_cells;
    idle(3);
    // R1: outputs during reset
    check(mem_req == 0 && done == 0, "R1 reset outputs", {mem_req, done}, 0);
    rst = 1'b0;
    idle(2);
    check(err_count == 0, "R1 err_count after reset", err_count, 0);
    check(inj_count == 0, "R1 inj_count after reset", inj_count, 0);

    // R5: inject before any fill
    start(0, 0, 0, 1, 8'd5);
    idle(6);
    check(inj_count == 1, "R5 inj_count", inj_count, 1);
    check(mem_arr[5] == 16'hFFFB, "R5 corrupted word", mem_arr[5], 16'hFFFB);

    // R2: fill pass
    start(1, 0, 0, 0, 8'd0);
    wait_done("R6 fill done");
    bad_cells = 0;
    for (int a = 0; a < N; a++) if (mem_arr[a] != good_word(a)) bad_cells++;
    check(bad_cells == 0, "R2 fill contents", bad_cells, 0);
    check(inj_count == 1, "R8 inj kept by fill", inj_count, 1);

    // R3: clean verify
    start(0, 1, 0, 0, 8'd0);
    wait_done("R6 verify done");
    check(err_count == 0, "R3 clean verify", err_count, 0);

    // R7: start pulse during an inject slot is ignored
    start(0, 0, 0, 1, 8'h21);
    start(1, 0, 0, 0, 8'd0);
    begin
      int reqs;
      reqs = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (mem_req) reqs++; end
      check(reqs == 0, "R7 busy start ignored", reqs, 0);
    end
    start(0, 0, 0, 1, 8'h80);
    idle(6);
    check(inj_count == 3, "R5 inj_count after two", inj_count, 3);

    // R3: verify reveals both injections
    start(0, 1, 0, 0, 8'd0);
    wait_done("R6 verify done 2");
    check(err_count == 2, "R3 injected errors", err_count, 2);

    // R7: fill wins over verify
    @(negedge clk); #1;
    go_write = 1; go_read = 1;
    @(negedge clk); #1;
    go_write = 0; go_read = 0;
    check(mem_req == 1 && mem_rd == 0, "R7 priority write first", {mem_req, mem_rd}, 2'b10);
    wait_done("R6 fill done 2");
    check(err_count == 2, "R8 err kept by fill", err_count, 2);
    check(inj_count == 3, "R8 inj kept", inj_count, 3);

    // R4: interleaved pass; 245 is read only inside the suppressed window
    start(0, 0, 0, 1, 8'd245);
    idle(6);
    fault_addr = 5;
    start(0, 0, 1, 0, 8'd0);
    wait_done("R6 interleaved done");
    fault_addr = -1;
    check(err_count == 3, "R4 interleaved one error", err_count, 3);
    check(mem_arr[245] == good_word(245), "R4 rewrite of 245", mem_arr[245], good_word(245));

    // R3 / R8: verify clears the count, sees only the faulted cell
    start(0, 1, 0, 0, 8'd0);
    wait_done("R6 verify done 3");
    check(err_count == 1, "R3 verify after clear", err_count, 1);

    // R8: only reset clears the injection count
    rst = 1'b1;
    idle(2);
    check(inj_count == 0 && err_count == 0, "R8 reset clears counts", {inj_count, err_count}, 0);
    rst = 1'b0;
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule